// File: doc/BRIEF.md
# Flash Erase Sequence Controller

This block sequences a multi-block flash erase under software control. Software sets an erase-mode bit in a small control register. It then makes one write to the flash array space, which acts as an interlock, and after that raises a start bit to launch the erase. A per-block select register, combined with a lock mask supplied from outside, decides which blocks are actually erased. A block is erased only when it is selected and not locked.

The erase itself is modelled by a cycle counter of fixed length. While the counter runs, software can abort the erase by clearing start, which reports a failure. Software can also suspend the erase once and resume it later; the count continues from where it stopped. Throughout an active or suspended erase, reads aimed at blocks being erased are flagged as invalid, and reads of every other block stay valid.

The interlock write also captures a shadow-enable input into an address-space status bit.

Top module: `erase_seq_ctrl`

## Requirements
- R1: After reset, every status bit of `ctl_rdata` is 0, `erase_blocks` is 0 and `rd_invalid` is 0.
- R2: A control write carries erase mode in bit 0, start in bit 1 and suspend in bit 2. The status word reads back mode (bit 0), start (bit 1), suspend (bit 2), done (bit 3), pass (bit 4) and address-space (bit 5). Writing mode=1 while idle makes the mode bit read 1.
- R3: A start request made outside erase mode, or made in erase mode before the interlock write, is ignored, and the start bit reads back 0.
- R4: The first array write after erase mode is set completes the interlock and copies `shadow_en` into status bit 5. Further array writes before start leave that bit unchanged.
- R5: Clearing the mode bit before start returns the block to idle, and no block is erased.
- R6: Start drives `erase_blocks` with select AND NOT lock, sampled at the start write. Exactly ERASE_CYCLES clock edges after the start edge, done and pass both read 1.
- R7: Clearing start after done makes done and start read 0. The next start then needs a new interlock write. Pass keeps its value until the next start.
- R8: Clearing start while an erase is running aborts it. Pass reads 0, done stays 0, `erase_blocks` goes to 0, and a new interlock is required.
- R9: A 0-to-1 suspend write during a running erase makes suspend read 1, freezes the count and sets `erase_blocks` to 0. A write of start=1 with suspend=0 resumes, and done arrives after the remaining count.
- R10: While suspended, a write that clears start is refused: start and suspend still read 1.
- R11: `rd_invalid` is 1 only when `rd_en` is high, an erase is running or suspended, and block `rd_blk` is in the erased set.
- R12: Writes to the select register while start reads 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data {suspend, start, mode} |
| ctl_rdata | output | 6 | Status {space, pass, done, suspend, start, mode} |
| sel_wr | input | 1 | Block select register write strobe |
| sel_wdata | input | NBLK | Block select write data |
| lock_mask | input | NBLK | Per-block lock, 1 = locked |
| arr_wr | input | 1 | Write to any flash array address (interlock) |
| shadow_en | input | 1 | Shadow enable, captured by the interlock |
| rd_en | input | 1 | Array read strobe |
| rd_blk | input | BLK_W | Block addressed by the read |
| rd_invalid | output | 1 | Read returns indeterminate data |
| erase_blocks | output | NBLK | Blocks under active erase |

## Verification
The erase is run with a partly locked select pattern, a fully locked pattern and an unchanged select after an ignored mid-erase write. These runs tell apart masking by lock, masking by select, and mask sampling at start. Start requests are issued with no mode, with mode but no interlock, and again after a completed sequence, which separates the interlock gate from the mode gate. Abort, refused abort while suspended, and a suspend-resume split at a known count distinguish a frozen counter from a reset or free-running one. Reads to selected-unlocked, selected-locked and unselected blocks show that the invalid flag follows the erased set rather than the raw select.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_READY = 3'd2,
        ST_RUN   = 3'd3,
        ST_SUSP  = 3'd4,
        ST_FIN   = 3'd5
    } esc_state_e;

    typedef struct packed {
        logic susp;
        logic hv;
        logic mode;
    } esc_ctl_t;

    typedef struct packed {
        logic space;
        logic pass;
        logic done;
        logic susp;
        logic hv;
        logic mode;
    } esc_stat_t;

    function automatic logic hv_visible(esc_state_e s);
        return (s == ST_RUN) || (s == ST_SUSP) || (s == ST_FIN);
    endfunction

endpackage

// File: rtl/esc_engine.sv
module esc_engine #(
    parameter int ERASE_CYCLES = 64,
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    output logic             finish,
    output logic [CNT_W-1:0] remain
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ERASE_CYCLES);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= LOAD_VAL;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign finish = run && (remain == CNT_W'(1));

    // R9: the count holds while the engine is neither loaded nor running
    p_count_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && !run) |=> $stable(remain));

endmodule

// File: rtl/esc_read_guard.sv
module esc_read_guard #(
    parameter int NBLK = 8,
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBLK-1:0]  target,
    input  logic             active,
    input  logic             rd_en,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rd_invalid
);
    logic [NBLK-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NBLK; g++) begin : g_hit
            assign hit[g] = target[g] && (rd_blk == BLK_W'(g));
        end
    endgenerate

    assign rd_invalid = rd_en && active && (|hit);

    // R11: invalid flag only on a read during an erase
    p_invalid_on_read_r11: assert property (@(posedge clk) disable iff (rst)
        rd_invalid |-> (rd_en && active));

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
    import erase_seq_pkg::*;
#(
    parameter int NBLK = 8,
    parameter int ERASE_CYCLES = 64,
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [2:0]       ctl_wdata,
    output logic [5:0]       ctl_rdata,
    input  logic             sel_wr,
    input  logic [NBLK-1:0]  sel_wdata,
    input  logic [NBLK-1:0]  lock_mask,
    input  logic             arr_wr,
    input  logic             shadow_en,
    input  logic             rd_en,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rd_invalid,
    output logic [NBLK-1:0]  erase_blocks
);
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

    esc_ctl_t        wr;
    esc_stat_t       stat;
    esc_state_e      st, st_nx;
    logic [NBLK-1:0] sel_q, tgt_q;
    logic            pass_q, space_q;
    logic            hv_vis, interlock, ctl_act_run, abort_req;
    logic            eng_load, eng_run, eng_finish;
    logic [CNT_W-1:0] eng_remain;

    assign wr          = esc_ctl_t'(ctl_wdata);
    assign hv_vis      = hv_visible(st);
    assign interlock   = (st == ST_ARMED) && arr_wr && !(ctl_wr && !wr.mode);
    assign ctl_act_run = ctl_wr && (!wr.hv || wr.susp);
    assign abort_req   = (st == ST_RUN) && ctl_wr && !wr.hv;
    assign eng_load    = (st == ST_READY) && ctl_wr && wr.mode && wr.hv;
    assign eng_run     = (st == ST_RUN) && !ctl_act_run;

    esc_engine #(.ERASE_CYCLES(ERASE_CYCLES)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .load   (eng_load),
        .run    (eng_run),
        .finish (eng_finish),
        .remain (eng_remain)
    );

    esc_read_guard #(.NBLK(NBLK)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .target     (tgt_q),
        .active     ((st == ST_RUN) || (st == ST_SUSP)),
        .rd_en      (rd_en),
        .rd_blk     (rd_blk),
        .rd_invalid (rd_invalid)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (ctl_wr && wr.mode) st_nx = ST_ARMED;
            ST_ARMED: begin
                if (ctl_wr && !wr.mode) st_nx = ST_IDLE;
                else if (arr_wr)        st_nx = ST_READY;
            end
            ST_READY: begin
                if (ctl_wr && !wr.mode)   st_nx = ST_IDLE;
                else if (ctl_wr && wr.hv) st_nx = ST_RUN;
            end
            ST_RUN: begin
                if (abort_req)                 st_nx = ST_ARMED;
                else if (ctl_wr && wr.susp)    st_nx = ST_SUSP;
                else if (eng_finish)           st_nx = ST_FIN;
            end
            ST_SUSP:  if (ctl_wr && wr.hv && !wr.susp) st_nx = ST_RUN;
            ST_FIN:   if (ctl_wr && !wr.hv) st_nx = ST_ARMED;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sel_q   <= '0;
            tgt_q   <= '0;
            pass_q  <= 1'b0;
            space_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (sel_wr && !hv_vis) sel_q <= sel_wdata;
            if (eng_load) tgt_q <= sel_q & ~lock_mask;
            if (interlock) space_q <= shadow_en;
            if (eng_load || abort_req) pass_q <= 1'b0;
            else if (eng_finish && !ctl_act_run) pass_q <= 1'b1;
        end
    end

    always_comb begin
        stat.mode  = (st != ST_IDLE);
        stat.hv    = hv_vis;
        stat.susp  = (st == ST_SUSP);
        stat.done  = (st == ST_FIN);
        stat.pass  = pass_q;
        stat.space = space_q;
    end

    assign ctl_rdata    = stat;
    assign erase_blocks = (st == ST_RUN) ? tgt_q : '0;

    // R6: done is only reported with start high
    p_done_with_hv_r6: assert property (@(posedge clk) disable iff (rst)
        stat.done |-> stat.hv);

    // R3: start can only become visible out of the interlocked state
    p_start_gated_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.hv) |-> ($past(st) == ST_READY));

    // R10: no abort while suspended
    p_no_abort_susp_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSP && ctl_wr) |=> stat.hv);

    // R8: abort reports failure and no done
    p_abort_fails_r8: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (!stat.pass && !stat.done && erase_blocks == '0));

    // R6: locked blocks are never driven for erase
    p_lock_skip_r6: assert property (@(posedge clk) disable iff (rst)
        eng_load |=> ((erase_blocks & $past(lock_mask)) == '0));

endmodule

// File: tb/erase_seq_ctrl_bench.sv
module erase_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBLK = 8;
    localparam int NCYC = 12;
    localparam int BLK_W = 3;

    logic clk = 0, rst = 1;
    logic ctl_wr = 0;
    logic [2:0] ctl_wdata = '0;
    logic [5:0] ctl_rdata;
    logic sel_wr = 0;
    logic [NBLK-1:0] sel_wdata = '0, lock_mask = '0, erase_blocks;
    logic arr_wr = 0, shadow_en = 0, rd_en = 0, rd_invalid;
    logic [BLK_W-1:0] rd_blk = '0;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    bit done_flag = 0;

    // behavioural reference: 0 idle,1 armed,2 ready,3 run,4 susp,5 fin
    int m_st = 0, m_cnt = 0;
    bit m_pass = 0, m_space = 0;
    logic [NBLK-1:0] m_sel = '0, m_tgt = '0;

    erase_seq_ctrl #(.NBLK(NBLK), .ERASE_CYCLES(NCYC)) u_erase_seq_ctrl (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .lock_mask(lock_mask), .arr_wr(arr_wr), .shadow_en(shadow_en),
        .rd_en(rd_en), .rd_blk(rd_blk), .rd_invalid(rd_invalid),
        .erase_blocks(erase_blocks)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int old;
        bit m, h, s;
        old = m_st;
        m = ctl_wdata[0]; h = ctl_wdata[1]; s = ctl_wdata[2];
        if (rst) begin
            m_st = 0; m_cnt = 0; m_pass = 0; m_space = 0; m_sel = '0; m_tgt = '0;
        end else begin
            case (old)
                0: if (ctl_wr && m) m_st = 1;
                1: if (ctl_wr && !m) m_st = 0;
                   else if (arr_wr) begin m_st = 2; m_space = shadow_en; end
                2: if (ctl_wr && !m) m_st = 0;
                   else if (ctl_wr && h) begin
                       m_st = 3; m_cnt = NCYC; m_pass = 0; m_tgt = m_sel & ~lock_mask;
                   end
                3: if (ctl_wr && !h) begin m_st = 1; m_pass = 0; end
                   else if (ctl_wr && s) m_st = 4;
                   else begin
                       m_cnt--;
                       if (m_cnt == 0) begin m_st = 5; m_pass = 1; end
                   end
                4: if (ctl_wr && h && !s) m_st = 3;
                5: if (ctl_wr && !h) m_st = 1;
                default: m_st = 0;
            endcase
            if (sel_wr && old < 3) m_sel = sel_wdata;
        end
    end

    always @(posedge clk) begin
        logic [5:0] exp_stat;
        logic [NBLK-1:0] exp_blk;
        bit exp_inv;
        #1;
        if (!rst && !done_flag) begin
            exp_stat = {m_space, m_pass, m_st == 5, m_st == 4, m_st >= 3, m_st != 0};
            exp_blk  = (m_st == 3) ? m_tgt : '0;
            exp_inv  = rd_en && (m_st == 3 || m_st == 4) && m_tgt[rd_blk];
            check({cur_req, " status"}, 32'(ctl_rdata), 32'(exp_stat));
            check({cur_req, " erase_blocks"}, 32'(erase_blocks), 32'(exp_blk));
            check({cur_req, " rd_invalid"}, 32'(rd_invalid), 32'(exp_inv));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_write(input bit m, input bit h, input bit s);
        @(negedge clk); ctl_wr = 1; ctl_wdata = {s, h, m};
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic arr_write(input bit sh);
        @(negedge clk); arr_wr = 1; shadow_en = sh;
        @(negedge clk); arr_wr = 0;
    endtask

    task automatic sel_write(input logic [NBLK-1:0] v);
        @(negedge clk); sel_wr = 1; sel_wdata = v;
        @(negedge clk); sel_wr = 0;
    endtask

    task automatic read_at(input int b, input bit exp, input string tag);
        @(negedge clk); rd_en = 1; rd_blk = BLK_W'(b);
        #1 check(tag, 32'(rd_invalid), 32'(exp));
        @(negedge clk); rd_en = 0;
    endtask

    task automatic finish_run;
        done_flag = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 0;
        #1;
        check("R1 status", 32'(ctl_rdata), 0);
        check("R1 erase_blocks", 32'(erase_blocks), 0);
        check("R1 rd_invalid", 32'(rd_invalid), 0);

        cur_req = "R3";
        ctl_write(0, 1, 0);
        check("R3 start without mode", 32'(ctl_rdata[1:0]), 0);
        cur_req = "R2";
        ctl_write(1, 1, 0);
        check("R2 mode set, R3 start ignored", 32'(ctl_rdata[1:0]), 1);
        cur_req = "R3";
        ctl_write(1, 1, 0);
        check("R3 start before interlock", 32'(ctl_rdata[1]), 0);

        cur_req = "R5";
        arr_write(1);
        ctl_write(0, 0, 0);
        check("R5 mode cleared", 32'(ctl_rdata[1:0]), 0);
        check("R5 no erase", 32'(erase_blocks), 0);

        cur_req = "R4";
        lock_mask = 8'h21;
        sel_write(8'hB5);
        ctl_write(1, 0, 0);
        arr_write(1);
        check("R4 space captured", 32'(ctl_rdata[5]), 1);
        arr_write(0);
        check("R4 second write ignored", 32'(ctl_rdata[5]), 1);

        cur_req = "R6";
        ctl_write(1, 1, 0);
        check("R6 start accepted", 32'(ctl_rdata[1]), 1);
        check("R6 select and not lock", 32'(erase_blocks), 32'h94);
        cur_req = "R11";
        read_at(2, 1, "R11 selected unlocked");
        read_at(0, 0, "R11 selected locked");
        read_at(1, 0, "R11 unselected");
        cur_req = "R12";
        sel_write(8'h0F);
        cur_req = "R6";
        idle(NCYC - 9);
        check("R6 done not early", 32'(ctl_rdata[3]), 0);
        idle(1);
        check("R6 done and pass", 32'(ctl_rdata[4:3]), 3);

        cur_req = "R7";
        ctl_write(1, 0, 0);
        check("R7 done cleared", 32'(ctl_rdata[3:1]), 0);
        check("R7 pass retained", 32'(ctl_rdata[4]), 1);
        ctl_write(1, 1, 0);
        check("R7 start needs new interlock", 32'(ctl_rdata[1]), 0);

        cur_req = "R12";
        arr_write(0);
        ctl_write(1, 1, 0);
        check("R12 select unchanged", 32'(erase_blocks), 32'h94);
        check("R4 space follows new interlock", 32'(ctl_rdata[5]), 0);

        cur_req = "R8";
        idle(3);
        ctl_write(1, 0, 0);
        check("R8 abort pass", 32'(ctl_rdata[4:3]), 0);
        check("R8 abort start", 32'(ctl_rdata[1]), 0);
        check("R8 abort mask", 32'(erase_blocks), 0);

        cur_req = "R9";
        arr_write(1);
        ctl_write(1, 1, 0);
        idle(4);
        ctl_write(1, 1, 1);
        check("R9 suspended", 32'(ctl_rdata[2:1]), 3);
        check("R9 mask off", 32'(erase_blocks), 0);
        read_at(7, 1, "R11 read while suspended");
        idle(20);
        check("R9 no done while suspended", 32'(ctl_rdata[3]), 0);
        cur_req = "R10";
        ctl_write(1, 0, 0);
        check("R10 abort refused", 32'(ctl_rdata[2:1]), 3);
        cur_req = "R9";
        ctl_write(1, 1, 0);
        check("R9 resumed", 32'(ctl_rdata[2:1]), 1);
        idle(NCYC - 6);
        check("R9 remaining count", 32'(ctl_rdata[3]), 0);
        idle(1);
        check("R9 done after resume", 32'(ctl_rdata[4:3]), 3);

        cur_req = "R6";
        ctl_write(1, 0, 0);
        lock_mask = 8'hFF;
        arr_write(0);
        ctl_write(1, 1, 0);
        check("R6 all locked", 32'(erase_blocks), 0);
        read_at(2, 0, "R11 locked block readable");
        idle(NCYC - 2);
        check("R6 completes with no blocks", 32'(ctl_rdata[4:3]), 3);

        idle(2);
        finish_run();
    end
endmodule